// File: doc/BRIEF.md
# Seed-Driven XOR Key Generator

This block derives an 8-byte XOR key from three inputs: a seed of variable length held in a local byte buffer, a 64-bit unique device identifier and an 8-bit device variant code. A host fills the seed buffer one byte at a time and pulses a capture strobe to latch a one-byte checksum of the identifier. It then sets the seed length and pulses `start`. A fixed number of cycles later the block presents the key. It also gives a status byte, which holds either the key checksum or an error code, and a one-cycle `done` pulse.

The key bytes come from seed positions set by two quotients of the seed length, one by 5 and one by 7. Each selected byte is XORed with the identifier checksum. The last key byte adds the variant code to the first one. A byte-wise decode port XORs an incoming data stream with the current key. The key byte is chosen by the byte's position within the current data field, and a marker input restarts that position count.

Top module: `xkey_gen`

## Requirements
- R1: After reset, `key` is zero, `key_valid`, `done` and `dec_out_valid` are 0, and `status` is 0x00.
- R2: A pulse on `uid_capture` stores the modulo-256 sum of the eight bytes of `uid` and arms key generation. If `start` is accepted before any capture, the run ends with `status` = 0xFD, `key` = 0 and `key_valid` = 0.
- R3: When `start` is high while the block is idle, the request is accepted. `done` is then high for exactly one cycle, which is the eighth clock edge after the accepting edge. A `start` while a run is in progress is ignored.
- R4: A run with a seed length below 30 ends with `status` = 0xFE, `key` = 0 and `key_valid` = 0. Here `seed_len` is the value sampled on the accepting edge, and a missing ID capture takes priority over this error.
- R5: A sampled seed length above 60 yields the same key as a length of 60.
- R6: With L the effective length, a = L/5 and b = L/7 (integer division), and c the stored ID checksum, key bytes 0 to 6 are seed[4b], seed[a], seed[b], seed[6b], seed[3b], seed[3a] and seed[5b], each XORed with c. Key byte k sits at `key[8k+7:8k]`.
- R7: Key byte 7 equals (key byte 0 + `variant`) modulo 256, using `variant` held steady during the run.
- R8: On a successful run, `key_valid` becomes 1 with `done`, and `status` equals the modulo-256 sum of the eight key bytes. `key_valid` drops on the edge that accepts the next `start`.
- R9: On each edge where `dec_valid` is 1, `dec_out` is loaded with `dec_in` XOR key byte (n mod 8), and `dec_out_valid` is 1 in the following cycle. Here n is the byte's position since the last byte flagged with `dec_first`, and the flagged byte itself has n = 0.
- R10: A write with `seed_wr_en` high stores `seed_wr_data` at seed position `seed_wr_addr`, and that byte is then used whenever the key formula selects that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_wr_en | input | 1 | Seed buffer write strobe |
| seed_wr_addr | input | 6 | Seed byte position to write |
| seed_wr_data | input | 8 | Seed byte value |
| seed_len | input | 8 | Seed length, sampled when a start is accepted |
| uid | input | 64 | Unique device identifier |
| uid_capture | input | 1 | Latch the identifier checksum and arm generation |
| variant | input | 8 | Device variant code |
| start | input | 1 | Begin a key computation |
| key | output | 64 | Computed key, byte k at bits 8k+7:8k |
| key_valid | output | 1 | Key holds a successful result |
| status | output | 8 | Key checksum or error code of the last run |
| done | output | 1 | One-cycle completion pulse |
| dec_valid | input | 1 | Encoded data byte present |
| dec_first | input | 1 | This byte starts a new data field |
| dec_in | input | 8 | Encoded data byte |
| dec_out | output | 8 | Decoded data byte |
| dec_out_valid | output | 1 | Decoded byte present |

## Verification
Key, status and `key_valid` change together with `done`, on the eighth edge after the accepting edge. A decoded byte appears one edge after its input. The identifier checksum and seed writes take effect on the edge that samples them. The bench steps a behavioural model on the same edges, with a countdown per run and a position counter for the decode stream. It compares every output at each falling edge, so a result one cycle early or late shows up as a mismatch. Directed checks after selected runs pin down specific key bytes, the length clamp and the variant byte.

// File: rtl/xkey_pkg.sv
// Shared constants, types and helpers for the seed-driven XOR key generator.
// Assumes byte-wide seed storage and an 8-byte key.
package xkey_pkg;
    localparam int KEY_BYTES  = 8;
    localparam int PICK_COUNT = 7;
    localparam int RUN_CYCLES = 8;

    localparam logic [7:0] ST_NO_ID = 8'hFD;
    localparam logic [7:0] ST_SHORT = 8'hFE;

    typedef enum logic [1:0] {
        KG_IDLE,
        KG_GATHER,
        KG_FINISH
    } kg_state_e;

    // Modulo-256 sum of the eight bytes of a 64-bit word.
    function automatic logic [7:0] byte_sum64(input logic [63:0] w);
        logic [7:0] acc;
        acc = 8'd0;
        for (int i = 0; i < 8; i++) begin
            acc = acc + w[8*i +: 8];
        end
        return acc;
    endfunction
endpackage

// File: rtl/xkey_seed_buf.sv
// Seed byte store: one synchronous write port and one combinational read port.
// Assumes the writer does not change contents while a key run reads them.
module xkey_seed_buf #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_q [DEPTH];

    // Clear on reset, otherwise store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'd0;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read of the addressed byte.
    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/xkey_index_calc.sv
// Seed position calculator: derives a = L/5 and b = L/7 by reciprocal
// multiplication and forms the seven seed positions used by the key.
// Assumes L <= 60 (the top clamps it); the reciprocals are exact in that range.
module xkey_index_calc #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [7:0]                len,
    output logic [6:0][AW-1:0]        pick
);
    localparam logic [15:0] RECIP5  = 16'd13;
    localparam int          SHIFT5  = 6;
    localparam logic [15:0] RECIP7  = 16'd37;
    localparam int          SHIFT7  = 8;

    logic [15:0] prod5, prod7;
    logic [7:0]  quo5, quo7;
    logic [7:0]  pos [7];

    // Reciprocal products standing in for the two divisions.
    always_comb begin
        prod5 = {8'd0, len} * RECIP5;
        prod7 = {8'd0, len} * RECIP7;
        quo5  = 8'(prod5 >> SHIFT5);
        quo7  = 8'(prod7 >> SHIFT7);
    end

    // Seed positions in key-byte order.
    always_comb begin
        pos[0] = quo7 * 8'd4;
        pos[1] = quo5;
        pos[2] = quo7;
        pos[3] = quo7 * 8'd6;
        pos[4] = quo7 * 8'd3;
        pos[5] = quo5 * 8'd3;
        pos[6] = quo7 * 8'd5;
    end

    genvar g;
    generate
        for (g = 0; g < 7; g++) begin : g_pick
            assign pick[g] = AW'(pos[g]);
        end
    endgenerate
endmodule

// File: rtl/xkey_decoder.sv
// Stream decoder: XORs each valid byte with the key byte chosen by its
// position in the current data field; output registered one cycle.
// Assumes the key input is stable while a field is being decoded.
module xkey_decoder (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] key,
    input  logic        in_valid,
    input  logic        in_first,
    input  logic [7:0]  in_data,
    output logic [7:0]  out_data,
    output logic        out_valid
);
    logic [2:0] pos_q;
    logic [2:0] pos_now;

    // Field start forces position zero.
    assign pos_now = in_first ? 3'd0 : pos_q;

    // Decode one byte and advance the position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= 3'd0;
            out_data  <= 8'd0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data ^ key[8*pos_now +: 8];
                pos_q    <= pos_now + 3'd1;
            end
        end
    end
endmodule

// File: rtl/xkey_gen.sv
// Seed-driven XOR key generator top. Captures an identifier checksum, then
// on start gathers seven seed bytes one per cycle, finishes with the variant
// byte and status, and pulses done a fixed eight cycles after start.
// Assumes seed, identifier and variant are held steady during a run.
module xkey_gen #(
    parameter int SEED_DEPTH = 64,
    parameter int MIN_LEN    = 30,
    parameter int MAX_LEN    = 60,
    localparam int AW        = $clog2(SEED_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seed_wr_en,
    input  logic [AW-1:0] seed_wr_addr,
    input  logic [7:0]    seed_wr_data,
    input  logic [7:0]    seed_len,
    input  logic [63:0]   uid,
    input  logic          uid_capture,
    input  logic [7:0]    variant,
    input  logic          start,
    output logic [63:0]   key,
    output logic          key_valid,
    output logic [7:0]    status,
    output logic          done,
    input  logic          dec_valid,
    input  logic          dec_first,
    input  logic [7:0]    dec_in,
    output logic [7:0]    dec_out,
    output logic          dec_out_valid
);
    import xkey_pkg::*;

    localparam logic [7:0] MAX_L8 = 8'(MAX_LEN);
    localparam logic [7:0] MIN_L8 = 8'(MIN_LEN);
    localparam logic [2:0] LAST_PICK = 3'(PICK_COUNT - 1);

    kg_state_e         state_q;
    logic [2:0]        step_q;
    logic [7:0]        len_q;
    logic [7:0]        id_chk_q;
    logic              id_armed_q;
    logic              no_id_q;
    logic              short_q;
    logic [7:0]        acc_q [PICK_COUNT];
    logic [63:0]       key_q;
    logic              kv_q;
    logic [7:0]        status_q;
    logic              done_q;

    logic [6:0][AW-1:0] pick;
    logic [AW-1:0]      rd_addr;
    logic [7:0]         rd_data;
    logic [7:0]         len_clamped;
    logic [7:0]         last_byte;
    logic [63:0]        key_next;

    // Clamp overlong seeds to the maximum length.
    assign len_clamped = (seed_len > MAX_L8) ? MAX_L8 : seed_len;

    xkey_seed_buf #(.DEPTH(SEED_DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seed_wr_en),
        .wr_addr (seed_wr_addr),
        .wr_data (seed_wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    xkey_index_calc #(.DEPTH(SEED_DEPTH)) u_idx (
        .len  (len_q),
        .pick (pick)
    );

    // Read the seed position for the current gather step.
    assign rd_addr = pick[step_q];

    // Assemble the finished key with the variant byte on top.
    always_comb begin
        last_byte = acc_q[0] + variant;
        key_next  = {last_byte, acc_q[6], acc_q[5], acc_q[4],
                     acc_q[3], acc_q[2], acc_q[1], acc_q[0]};
    end

    // Latch the identifier checksum and arm generation on a capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_chk_q   <= 8'd0;
            id_armed_q <= 1'b0;
        end else if (uid_capture) begin
            id_chk_q   <= byte_sum64(uid);
            id_armed_q <= 1'b1;
        end
    end

    // Run sequencer: accept, gather seven bytes, finish and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= KG_IDLE;
            step_q   <= 3'd0;
            len_q    <= 8'd0;
            no_id_q  <= 1'b0;
            short_q  <= 1'b0;
            key_q    <= 64'd0;
            kv_q     <= 1'b0;
            status_q <= 8'd0;
            done_q   <= 1'b0;
            for (int i = 0; i < PICK_COUNT; i++) begin
                acc_q[i] <= 8'd0;
            end
        end else begin
            unique case (state_q)
                KG_IDLE: begin
                    done_q <= 1'b0;
                    if (start) begin
                        kv_q    <= 1'b0;
                        len_q   <= len_clamped;
                        no_id_q <= !id_armed_q;
                        short_q <= (seed_len < MIN_L8);
                        step_q  <= 3'd0;
                        state_q <= KG_GATHER;
                    end
                end
                KG_GATHER: begin
                    acc_q[step_q] <= rd_data ^ id_chk_q;
                    if (step_q == LAST_PICK) begin
                        state_q <= KG_FINISH;
                    end else begin
                        step_q <= step_q + 3'd1;
                    end
                end
                KG_FINISH: begin
                    done_q  <= 1'b1;
                    state_q <= KG_IDLE;
                    step_q  <= 3'd0;
                    if (no_id_q) begin
                        status_q <= ST_NO_ID;
                        key_q    <= 64'd0;
                        kv_q     <= 1'b0;
                    end else if (short_q) begin
                        status_q <= ST_SHORT;
                        key_q    <= 64'd0;
                        kv_q     <= 1'b0;
                    end else begin
                        status_q <= byte_sum64(key_next);
                        key_q    <= key_next;
                        kv_q     <= 1'b1;
                    end
                end
                default: state_q <= KG_IDLE;
            endcase
        end
    end

    xkey_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .key       (key_q),
        .in_valid  (dec_valid),
        .in_first  (dec_first),
        .in_data   (dec_in),
        .out_data  (dec_out),
        .out_valid (dec_out_valid)
    );

    assign key       = key_q;
    assign key_valid = kv_q;
    assign status    = status_q;
    assign done      = done_q;
endmodule

// File: rtl/xkey_gen_checks.sv
// Property checker for xkey_gen, attached by bind. Tracks run timing with
// its own countdown rather than deep history.
module xkey_gen_checks #(
    parameter int RUN = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        done,
    input logic [63:0] key,
    input logic        key_valid,
    input logic [7:0]  status,
    input logic [7:0]  variant,
    input logic        dec_valid,
    input logic        dec_out_valid
);
    logic [3:0] cnt_q;
    logic       done_exp_q;
    logic [7:0] key_sum;

    // Independent countdown of an accepted run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= 4'd0;
            done_exp_q <= 1'b0;
        end else begin
            done_exp_q <= (cnt_q == 4'd1);
            if (cnt_q != 4'd0) begin
                cnt_q <= cnt_q - 4'd1;
            end else if (start) begin
                cnt_q <= 4'(RUN);
            end
        end
    end

    // Sum of the key bytes as seen at the port.
    always_comb begin
        key_sum = 8'd0;
        for (int i = 0; i < 8; i++) begin
            key_sum = key_sum + key[8*i +: 8];
        end
    end

    p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done == done_exp_q);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_key_moves_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (key != $past(key)) |-> done);

    p_status_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (status == key_sum));

    p_error_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !key_valid) |-> (status == 8'hFE || status == 8'hFD));

    p_top_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_valid) |-> (key[63:56] == 8'(key[7:0] + $past(variant))));

    p_dec_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> dec_out_valid);

    p_dec_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> !dec_out_valid);
endmodule

bind xkey_gen xkey_gen_checks #(.RUN(8)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .done          (done),
    .key           (key),
    .key_valid     (key_valid),
    .status        (status),
    .variant       (variant),
    .dec_valid     (dec_valid),
    .dec_out_valid (dec_out_valid)
);

// File: tb/xkey_gen_test.sv
module xkey_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_wr_en = 1'b0;
    logic [5:0]  seed_wr_addr = '0;
    logic [7:0]  seed_wr_data = '0;
    logic [7:0]  seed_len = '0;
    logic [63:0] uid = '0;
    logic        uid_capture = 1'b0;
    logic [7:0]  variant = '0;
    logic        start = 1'b0;
    logic [63:0] key;
    logic        key_valid;
    logic [7:0]  status;
    logic        done;
    logic        dec_valid = 1'b0;
    logic        dec_first = 1'b0;
    logic [7:0]  dec_in = '0;
    logic [7:0]  dec_out;
    logic        dec_out_valid;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    xkey_gen uut (
        .clk(clk), .rst_n(rst_n),
        .seed_wr_en(seed_wr_en), .seed_wr_addr(seed_wr_addr), .seed_wr_data(seed_wr_data),
        .seed_len(seed_len), .uid(uid), .uid_capture(uid_capture), .variant(variant),
        .start(start), .key(key), .key_valid(key_valid), .status(status), .done(done),
        .dec_valid(dec_valid), .dec_first(dec_first), .dec_in(dec_in),
        .dec_out(dec_out), .dec_out_valid(dec_out_valid)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_seed [64];
    int m_chk, m_idok, m_cnt;
    int m_key [8];
    int p_key [8];
    int m_status, p_status, m_kv, p_kv, m_done;
    string m_tag = "R8";
    string p_tag = "R8";
    int m_pos, m_dout, m_dov;

    function automatic logic [63:0] pack_key();
        logic [63:0] r = '0;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = 8'(m_key[i]);
        return r;
    endfunction

    function automatic int uid_sum(input logic [63:0] u);
        int s = 0;
        for (int i = 0; i < 8; i++) s += u[8*i +: 8];
        return s % 256;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_seed[i]) m_seed[i] = 0;
            foreach (m_key[i]) m_key[i] = 0;
            m_chk = 0; m_idok = 0; m_cnt = 0; m_status = 0; m_kv = 0; m_done = 0;
            m_pos = 0; m_dout = 0; m_dov = 0; m_tag = "R8";
        end else begin
            // decode with the key held before this edge
            m_dov = dec_valid;
            if (dec_valid) begin
                int n;
                n = dec_first ? 0 : m_pos;
                m_dout = dec_in ^ m_key[n];
                m_pos = (n + 1) % 8;
            end
            // run countdown
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_key = p_key; m_status = p_status; m_kv = p_kv; m_tag = p_tag;
                    m_done = 1;
                end
            end else if (start) begin
                int len, a, b;
                m_cnt = 8; m_kv = 0;
                len = (seed_len > 60) ? 60 : seed_len;
                a = len / 5; b = len / 7;
                p_key[0] = m_seed[4*b] ^ m_chk;
                p_key[1] = m_seed[a]   ^ m_chk;
                p_key[2] = m_seed[b]   ^ m_chk;
                p_key[3] = m_seed[6*b] ^ m_chk;
                p_key[4] = m_seed[3*b] ^ m_chk;
                p_key[5] = m_seed[3*a] ^ m_chk;
                p_key[6] = m_seed[5*b] ^ m_chk;
                p_key[7] = (p_key[0] + variant) % 256;
                if (!m_idok) begin
                    foreach (p_key[i]) p_key[i] = 0;
                    p_status = 'hFD; p_kv = 0; p_tag = "R2";
                end else if (seed_len < 30) begin
                    foreach (p_key[i]) p_key[i] = 0;
                    p_status = 'hFE; p_kv = 0; p_tag = "R4";
                end else begin
                    p_status = 0;
                    foreach (p_key[i]) p_status += p_key[i];
                    p_status = p_status % 256; p_kv = 1; p_tag = "R8";
                end
            end
            if (seed_wr_en) m_seed[seed_wr_addr] = seed_wr_data;
            if (uid_capture) begin m_chk = uid_sum(uid); m_idok = 1; end
        end
    end

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 done", 64'(done), 64'(m_done));
            check({m_tag, " status"}, 64'(status), 64'(m_status));
            check("R8 key_valid", 64'(key_valid), 64'(m_kv));
            check("R6 key", key, pack_key());
            check("R9 dec_out_valid", 64'(dec_out_valid), 64'(m_dov));
            if (m_dov) check("R9 dec_out", 64'(dec_out), 64'(m_dout));
        end
    end

    // ---------------- stimulus ----------------
    task automatic write_seed(input int pattern);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            seed_wr_en = 1'b1; seed_wr_addr = 6'(i);
            seed_wr_data = (pattern == 0) ? 8'd0 : 8'(i * 7 + 3);
        end
        @(negedge clk); seed_wr_en = 1'b0;
    endtask

    task automatic capture(input logic [63:0] u);
        @(negedge clk); uid = u; uid_capture = 1'b1;
        @(negedge clk); uid_capture = 1'b0;
    endtask

    task automatic run_key(input int len, input int var_code);
        @(negedge clk); seed_len = 8'(len); variant = 8'(var_code); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (9) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic first);
        @(negedge clk); dec_valid = 1'b1; dec_first = first; dec_in = b;
        @(negedge clk); dec_valid = 1'b0; dec_first = 1'b0;
    endtask

    logic [63:0] key60;
    logic [7:0]  chk_a;

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 key", key, 64'd0);
        check("R1 key_valid", 64'(key_valid), 64'd0);
        check("R1 status", 64'(status), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 dec_out_valid", 64'(dec_out_valid), 64'd0);
        rst_n = 1'b1;

        write_seed(1);
        run_key(60, 'h30);                       // R2: no ID captured yet
        check("R2 status no id", 64'(status), 64'hFD);

        capture(64'h0123_4567_89AB_CDEF);
        chk_a = 8'(uid_sum(64'h0123_4567_89AB_CDEF));
        run_key(60, 'h30);
        key60 = key;
        // R10: L=60 -> b=8, byte0 from position 32 written as 32*7+3
        check("R10 seed byte used", 64'(key[7:0]), 64'(8'(32*7+3) ^ chk_a));
        check("R7 top byte", 64'(key[63:56]), 64'(8'(key[7:0] + 8'h30)));

        run_key(30, 'h31);
        run_key(29, 'h31);                       // R4: short seed
        check("R4 status short", 64'(status), 64'hFE);
        run_key(45, 'h32);
        run_key(200, 'h30);                      // R5: clamp to 60
        check("R5 clamp key", key, key60);
        run_key(0, 'h30);

        // R3: second start during a run is ignored
        @(negedge clk); seed_len = 8'd50; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1; seed_len = 8'd31;
        @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);

        // R9: decode stream with field restarts
        run_key(60, 'h33);
        for (int i = 0; i < 20; i++) send_byte(8'(i * 13 + 1), (i == 0) || (i == 11));
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); dec_valid = 1'b1; dec_first = (i == 4); dec_in = 8'(255 - i);
        end
        @(negedge clk); dec_valid = 1'b0; dec_first = 1'b0;

        // zero seed and a fresh identifier
        write_seed(0);
        capture(64'hFEDC_BA98_7654_3210);
        run_key(52, 'h33);
        check("R6 zero seed byte", 64'(key[23:16]),
              64'(uid_sum(64'hFEDC_BA98_7654_3210)));

        // varied seeds and lengths
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 64; i++) begin
                @(negedge clk); seed_wr_en = 1'b1; seed_wr_addr = 6'(i);
                seed_wr_data = 8'($urandom_range(0, 255));
            end
            @(negedge clk); seed_wr_en = 1'b0;
            capture({$urandom, $urandom});
            run_key($urandom_range(25, 70), $urandom_range(0, 255));
            for (int i = 0; i < 9; i++) send_byte(8'($urandom_range(0, 255)), i == 0);
        end

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule